// File: doc/BRIEF.md
# DAC Code Source Selector

This block produces the 8-bit code that drives a digital-to-analog converter. The code can come from four places: an 8-bit parallel bus that is written with a chip-select pulse, a serial port that shifts bits in least significant bit first, a word loaded through the test access port and marked by a one-cycle update strobe, and a code read from nonvolatile storage. Two level pins select the source. `serial_en` high always selects the serial port. With `serial_en` low, `par_mode` decides between parallel writes and the stored code. Chip select, serial clock and serial data are asynchronous pins. Each passes through a two-flop synchroniser, and all edges are detected in the system clock domain.

A four-state source machine holds the output register. SRC_PARALLEL is the reset state and shows the parallel latch, which resets to mid-scale 80h. SRC_STORED tracks `stored_code`. SRC_JTAG holds the last word from the test port. SRC_SERIAL holds the last complete serial word. The transitions are:
- **enter_serial**: any state goes to SRC_SERIAL while `serial_en` is high.
- **jtag_load**: any state goes to SRC_JTAG on a strobe while `serial_en` is low.
- **par_write**: any state goes to SRC_PARALLEL on a chip-select rising edge with `par_mode` high.
- **select_stored**: SRC_PARALLEL, SRC_STORED or SRC_SERIAL goes to SRC_STORED when `par_mode` is low and no parallel write has happened since reset.
- **select_parallel**: the same three states go to SRC_PARALLEL in every other case.
- **jtag_hold**: SRC_JTAG stays where it is until one of the first three transitions fires.

Top module: `dac_code_select`

## Requirements
- R1: While reset is asserted, and afterwards in parallel mode until the first parallel write, `dac_code` is 80h and `code_valid` is 0.
- R2: With `serial_en` low, `par_mode` low and no parallel write since reset, `dac_code` follows `stored_code` within a few cycles of each change.
- R3: With `serial_en` low and `par_mode` high, a rising edge of `cs_n` captures `par_data` into the parallel latch and onto `dac_code`.
- R4: After the first parallel write, `par_mode` low no longer selects the stored code. `dac_code` keeps the parallel latch value and ignores changes of `stored_code`.
- R5: While `serial_en` is high, `par_data` and `stored_code` have no effect. `sdi` is sampled on each rising `sclk` edge while `cs_n` is low, and the first bit becomes bit 0. A rising `cs_n` edge after at least 8 bits loads the last 8 bits onto `dac_code`.
- R6: A rising `cs_n` edge in serial mode after fewer than 8 bits leaves `dac_code` unchanged. Every falling `cs_n` edge clears the bit count.
- R7: With `serial_en` low, a `jtag_upd` pulse loads `jtag_word` onto `dac_code` on the next clock edge. This works any number of times. The word is held against `stored_code` changes until a parallel write or serial mode.
- R8: While `serial_en` is high, `jtag_upd` has no effect.
- R9: `code_valid` is high for exactly one cycle each time the output register is loaded, including a parallel write of the value already shown. It is low otherwise.
- R10: When `serial_en` falls, `dac_code` returns to the parallel latch if a parallel write has happened, and to `stored_code` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_en | input | 1 | High selects the serial port |
| par_mode | input | 1 | High selects parallel writes, low selects the stored code |
| cs_n | input | 1 | Active-low chip select; its rising edge commits a word |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data, least significant bit first |
| par_data | input | 8 | Parallel data bus |
| jtag_word | input | 8 | Word from the test data register |
| jtag_upd | input | 1 | One-cycle update strobe for `jtag_word` |
| stored_code | input | 8 | Code from nonvolatile storage |
| dac_code | output | 8 | Registered converter code |
| code_valid | output | 1 | One-cycle pulse on each load of `dac_code` |

## Verification
The hardest state to reach is the stored-code selection. It exists only between a reset and the first parallel write, so the bench applies a second reset with `par_mode` low. While that window is open, it tests stored-code tracking, test-port overrides and the return from serial mode. Only after that does it make the first parallel write. Serial-mode cases follow in order: a short frame, then a full frame, then a test-port strobe while serial mode is active. Together they check that a short frame or an ignored strobe leaves the previous full word in place.

// File: rtl/dac_sel_pkg.sv
package dac_sel_pkg;
    typedef enum logic [1:0] {
        SRC_STORED,
        SRC_PARALLEL,
        SRC_JTAG,
        SRC_SERIAL
    } src_state_e;
endpackage

// File: rtl/dac_pin_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins (STAGES >= 2).
module dac_pin_sync #(
    parameter int                 WIDTH  = 3,
    parameter int                 STAGES = 2,
    parameter logic [WIDTH-1:0]   INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_lvl
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{INIT}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], pin_in};
        end
    end

    assign pin_lvl = stage_q[STAGES-1];
endmodule

// File: rtl/dac_spi_shift.sv
// Serial shift register: LSB first, bit count saturating at CODE_W.
module dac_spi_shift #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              sdi_s,
    output logic [CODE_W-1:0] word,
    output logic              full
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CODE_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (enable && cs_low && sclk_rise) begin
            shreg_q <= {sdi_s, shreg_q[CODE_W-1:1]};
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word = shreg_q;
    assign full = (cnt_q == CNT_MAX);
endmodule

// File: rtl/dac_src_fsm.sv
// Source-selection state machine and output code register.
module dac_src_fsm
    import dac_sel_pkg::*;
#(
    parameter int                CODE_W     = 8,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_en,
    input  logic              par_mode,
    input  logic              jtag_upd,
    input  logic [CODE_W-1:0] jtag_word,
    input  logic [CODE_W-1:0] par_data,
    input  logic [CODE_W-1:0] stored_code,
    input  logic              cs_rise,
    input  logic [CODE_W-1:0] spi_word,
    input  logic              spi_full,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid
);
    src_state_e        state_q, state_d;
    logic [CODE_W-1:0] par_latch_q;
    logic              par_seen_q;
    logic [CODE_W-1:0] dac_q;
    logic              valid_q;
    logic              par_wr;
    logic              load;
    logic [CODE_W-1:0] load_val;

    // Next-state selection: serial, then test port, then parallel/stored.
    always_comb begin
        state_d = state_q;
        if (serial_en) begin
            state_d = SRC_SERIAL;
        end else if (jtag_upd) begin
            state_d = SRC_JTAG;
        end else if (cs_rise && par_mode) begin
            state_d = SRC_PARALLEL;
        end else begin
            unique case (state_q)
                SRC_JTAG:     state_d = SRC_JTAG;
                SRC_STORED,
                SRC_PARALLEL,
                SRC_SERIAL:   state_d = (!par_mode && !par_seen_q) ? SRC_STORED
                                                                   : SRC_PARALLEL;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_PARALLEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Output load decision.
    always_comb begin
        load     = 1'b0;
        load_val = dac_q;
        par_wr   = 1'b0;
        if (serial_en) begin
            if (cs_rise && spi_full) begin
                load     = 1'b1;
                load_val = spi_word;
            end
        end else if (jtag_upd) begin
            load     = 1'b1;
            load_val = jtag_word;
        end else if (cs_rise && par_mode) begin
            par_wr   = 1'b1;
            load     = 1'b1;
            load_val = par_data;
        end else begin
            unique case (state_d)
                SRC_STORED: begin
                    if (stored_code != dac_q) begin
                        load     = 1'b1;
                        load_val = stored_code;
                    end
                end
                SRC_PARALLEL: begin
                    if (par_latch_q != dac_q) begin
                        load     = 1'b1;
                        load_val = par_latch_q;
                    end
                end
                SRC_JTAG,
                SRC_SERIAL: begin
                    load = 1'b0;
                end
            endcase
        end
    end

    // Output and parallel latch registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q       <= RESET_CODE;
            valid_q     <= 1'b0;
            par_latch_q <= RESET_CODE;
            par_seen_q  <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                dac_q <= load_val;
            end
            if (par_wr) begin
                par_latch_q <= par_data;
                par_seen_q  <= 1'b1;
            end
        end
    end

    assign dac_code   = dac_q;
    assign code_valid = valid_q;
endmodule

// File: rtl/dac_code_select.sv
module dac_code_select #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_en,
    input  logic              par_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [CODE_W-1:0] par_data,
    input  logic [CODE_W-1:0] jtag_word,
    input  logic              jtag_upd,
    input  logic [CODE_W-1:0] stored_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid
);
    localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(1) << (CODE_W - 1);
    // Pin group order {sdi, sclk, cs_n}; chip select idles high.
    localparam logic [2:0]        PIN_INIT   = 3'b001;

    logic [2:0]        pin_lvl;
    logic [1:0]        edge_q;
    logic              cs_rise, cs_fall, sclk_rise;
    logic [CODE_W-1:0] spi_word;
    logic              spi_full;

    dac_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_INIT)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({sdi, sclk, cs_n}),
        .pin_lvl (pin_lvl)
    );

    // Previous synchronised levels of sclk and cs_n for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= PIN_INIT[1:0];
        end else begin
            edge_q <= pin_lvl[1:0];
        end
    end

    assign cs_rise   =  pin_lvl[0] & ~edge_q[0];
    assign cs_fall   = ~pin_lvl[0] &  edge_q[0];
    assign sclk_rise =  pin_lvl[1] & ~edge_q[1];

    dac_spi_shift #(
        .CODE_W (CODE_W)
    ) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (serial_en),
        .cs_low    (~pin_lvl[0]),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .sdi_s     (pin_lvl[2]),
        .word      (spi_word),
        .full      (spi_full)
    );

    dac_src_fsm #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_en   (serial_en),
        .par_mode    (par_mode),
        .jtag_upd    (jtag_upd),
        .jtag_word   (jtag_word),
        .par_data    (par_data),
        .stored_code (stored_code),
        .cs_rise     (cs_rise),
        .spi_word    (spi_word),
        .spi_full    (spi_full),
        .dac_code    (dac_code),
        .code_valid  (code_valid)
    );
endmodule

// File: rtl/dac_code_select_chk.sv
module dac_code_select_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              serial_en,
    input logic              par_mode,
    input logic              jtag_upd,
    input logic [CODE_W-1:0] jtag_word,
    input logic [CODE_W-1:0] par_data,
    input logic              cs_rise,
    input logic [CODE_W-1:0] dac_code,
    input logic              code_valid
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic rst_edge_seen = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) rst_edge_seen <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n && rst_edge_seen) begin
            assert_reset_mid_R1: assert (dac_code == MID && !code_valid)
                else $error("reset code wrong");
        end
    end

    assert_par_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && par_mode && !serial_en && !jtag_upd) |=> dac_code == $past(par_data));

    assert_serial_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(serial_en) && code_valid) |-> $past(cs_rise));

    assert_jtag_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_upd && !serial_en) |=> dac_code == $past(jtag_word));

    assert_hold_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(dac_code));
endmodule

bind dac_code_select dac_code_select_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .serial_en  (serial_en),
    .par_mode   (par_mode),
    .jtag_upd   (jtag_upd),
    .jtag_word  (jtag_word),
    .par_data   (par_data),
    .cs_rise    (cs_rise),
    .dac_code   (dac_code),
    .code_valid (code_valid)
);

// File: tb/dac_code_select_bench.sv
module dac_code_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {op[3:0], value[7:0], expected code[7:0], expected pulses[1:0]}
    // op: 0 par write, 1 serial 8 bits, 2 serial 5 bits, 3 test-port load,
    //     4 stored change with par_mode low, 5 leave serial, 6 strobe in serial,
    //     7 cs pulse in serial with no bits while par_data changes
    localparam logic [21:0] VEC [NV] = '{
        {4'd0, 8'h11, 8'h11, 2'd1},   // R3
        {4'd0, 8'hFE, 8'hFE, 2'd1},   // R3
        {4'd4, 8'h22, 8'hFE, 2'd0},   // R4
        {4'd3, 8'h5A, 8'h5A, 2'd1},   // R7
        {4'd0, 8'h00, 8'h00, 2'd1},   // R3
        {4'd1, 8'h96, 8'h96, 2'd1},   // R5
        {4'd2, 8'h0F, 8'h96, 2'd0},   // R6
        {4'd1, 8'h01, 8'h01, 2'd1},   // R5
        {4'd6, 8'h77, 8'h01, 2'd0},   // R8
        {4'd7, 8'hC4, 8'h01, 2'd0},   // R5
        {4'd5, 8'h00, 8'h00, 2'd1},   // R10
        {4'd0, 8'h00, 8'h00, 2'd1}    // R9 rewrite of equal value
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_en = 1'b0;
    logic       par_mode = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] par_data = 8'h00;
    logic [7:0] jtag_word = 8'h00;
    logic       jtag_upd = 1'b0;
    logic [7:0] stored_code = 8'h00;
    logic [7:0] dac_code;
    logic       code_valid;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    int base = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (code_valid) pulses++;

    dac_code_select u_dac_code_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_en   (serial_en),
        .par_mode    (par_mode),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .par_data    (par_data),
        .jtag_word   (jtag_word),
        .jtag_upd    (jtag_upd),
        .stored_code (stored_code),
        .dac_code    (dac_code),
        .code_valid  (code_valid)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic par_write(input logic [7:0] v);
        serial_en = 1'b0;
        par_mode  = 1'b1;
        par_data  = v;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(6);
        cs_n = 1'b1;
        wait_n(8);
    endtask

    task automatic spi_send(input logic [7:0] v, input int nbits);
        serial_en = 1'b1;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(6);
        for (int i = 0; i < nbits; i++) begin
            sdi = v[i];
            wait_n(4);
            sclk = 1'b1;
            wait_n(4);
            sclk = 1'b0;
            wait_n(2);
        end
        cs_n = 1'b1;
        wait_n(8);
    endtask

    task automatic jtag_load(input logic [7:0] v);
        jtag_word = v;
        jtag_upd  = 1'b1;
        wait_n(1);
        jtag_upd  = 1'b0;
        wait_n(3);
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R5";
            4'd2: return "R6";
            4'd3: return "R7";
            4'd4: return "R4";
            4'd5: return "R10";
            4'd6: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state with parallel mode selected
        wait_n(3);
        check("R1", "code in reset", dac_code, 8'h80);
        check("R1", "valid in reset", code_valid, 0);
        base = pulses;
        rst_n = 1'b1;
        wait_n(5);
        check("R1", "code after reset", dac_code, 8'h80);
        check("R9", "pulses after reset", pulses - base, 0);

        // R2: second reset with stored-code selection
        rst_n = 1'b0;
        par_mode = 1'b0;
        stored_code = 8'h3C;
        wait_n(3);
        base = pulses;
        rst_n = 1'b1;
        wait_n(4);
        check("R2", "stored at start", dac_code, 8'h3C);
        check("R9", "one load pulse", pulses - base, 1);
        stored_code = 8'hA5;
        wait_n(4);
        check("R2", "stored tracked", dac_code, 8'hA5);

        // R7: test-port loads override the stored code
        jtag_load(8'hC3);
        check("R7", "jtag load", dac_code, 8'hC3);
        stored_code = 8'h10;
        wait_n(5);
        check("R7", "jtag held", dac_code, 8'hC3);
        jtag_load(8'h44);
        check("R7", "jtag reload", dac_code, 8'h44);

        // R10: leaving serial mode before any parallel write returns to stored
        serial_en = 1'b1;
        wait_n(4);
        serial_en = 1'b0;
        wait_n(4);
        check("R10", "back to stored", dac_code, 8'h10);

        // R1: parallel mode without a write shows the mid-scale latch
        par_mode = 1'b1;
        wait_n(4);
        check("R1", "latch mid-scale", dac_code, 8'h80);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [7:0] val;
            logic [7:0] exp_code;
            logic [1:0] exp_p;
            op       = VEC[i][21:18];
            val      = VEC[i][17:10];
            exp_code = VEC[i][9:2];
            exp_p    = VEC[i][1:0];
            base = pulses;
            case (op)
                4'd0: par_write(val);
                4'd1: spi_send(val, 8);
                4'd2: spi_send(val, 5);
                4'd3: jtag_load(val);
                4'd4: begin
                    serial_en = 1'b0;
                    par_mode = 1'b0;
                    stored_code = val;
                    wait_n(6);
                end
                4'd5: begin
                    serial_en = 1'b0;
                    par_mode = 1'b1;
                    wait_n(6);
                end
                4'd6: jtag_load(val);
                default: begin
                    par_data = val;
                    spi_send(val, 0);
                end
            endcase
            check(req_of(op), $sformatf("vector %0d code", i), dac_code, exp_code);
            check("R9", $sformatf("vector %0d pulses", i), pulses - base, exp_p);
        end

        finish_run();
    end
endmodule